// File: doc/BRIEF.md
# Format-Selectable I2S Transmit Serializer

This block turns pairs of 16-bit audio samples into a one-bit serial stream with a word-select line and a bit clock. Every part of it runs in the system clock domain. In clock-master mode it divides the system clock to make the bit clock and drives both the bit clock and word select itself. In clock-slave mode it follows a bit clock and word select that come from outside. It brings them in through two-flop synchronizers and reacts to the falling edges it detects.

A 2-bit format code chooses the framing. Code 2 gives left-justified framing, where the most significant bit goes out in the same bit period as the word-select transition. Every other code gives standard I2S framing, where each word starts one bit period after the word-select transition. A producer offers sample pairs on a ready/valid port. The block accepts one pair at each frame boundary. If no pair is waiting at a boundary, the block sends a frame of silence and records the event in a sticky flag.

Top module: `i2s_tx_serializer`

## Requirements
- R1: With format code 2, each 32-bit-clock frame carries the left sample in bit periods 0..15 and the right sample in periods 16..31, each sent most significant bit first. The MSB of each word goes out in the bit period where word select changes.
- R2: With format code 0, every data bit is sent one bit period later than in R1. The first period after each word-select change therefore carries the LSB of the previous word.
- R3: Format codes 1 and 3 give exactly the serial output of code 0.
- R4: In master mode, word select is low for the 16 bit periods of the left word and high for the 16 periods of the right word. It changes only at frame slot 0 and slot 16. It is high after reset.
- R5: In master mode, the bit clock starts low after reset and toggles every DIV_HALF system cycles. Serial data and word select change only on the system edge at which the bit clock falls.
- R6: The size code has no effect on the output. Every code gives 16-bit words, and code 3 gives the same stream as code 0.
- R7: `s_ready` is high for exactly the one system cycle that ends with the falling bit-clock edge that opens a frame. A pair offered with `s_valid` high in that cycle is the one sent in that frame.
- R8: If `s_valid` is low in the cycle `s_ready` is high, that frame is all zeros and `underflow` rises. `underflow` then stays high until reset.
- R9: In slave mode, `sck_out` and `ws_out` stay low. A frame starts at the first external bit-clock fall where the external word select is low after having been high. The bit that falls begins goes out three system cycles after that external fall. The mapping of bits to slots follows R1 or R2.
- R10: During reset `sd_out`, `sck_out`, `s_ready` and `underflow` are low. `ws_out` is high in master mode and low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1: drive bit clock and word select; 0: follow external ones |
| cfg_fmt | input | 2 | Framing code: 2 left-justified, others standard I2S |
| cfg_size | input | 2 | Word size code; all codes mean 16 bits |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Pair taken this cycle (frame boundary) |
| s_left | input | 16 | Left-channel sample |
| s_right | input | 16 | Right-channel sample |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sck_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| sd_out | output | 1 | Serial data |
| underflow | output | 1 | Sticky: a frame went out without a pair |

## Verification
The hardest condition to reach from the ports is a frame boundary with no pair waiting, followed by the stream recovering. The bench drops `s_valid` for a stretch longer than one frame while the master keeps running, then restores it. The reference model checks that the silent frame is all zeros, that the next pair goes out intact, and that the flag stays set. Slave alignment is also hard to reach, because it depends on the synchronizer delay. The bench drives its own slower external clocks and compares every system cycle against a model that carries the same three-cycle latency stated in R9.

// File: rtl/i2stx_pkg.sv
// Package: shared encodings and decode helpers for the I2S transmit serializer.
// Assumes: format and size codes are 2 bits wide and held static between resets.
package i2stx_pkg;

    typedef enum logic [1:0] {
        FMT_STD   = 2'd0,
        FMT_RSV_A = 2'd1,
        FMT_LEFT  = 2'd2,
        FMT_RSV_B = 2'd3
    } fmt_e;

    // True when the framing code selects left-justified (no one-bit delay).
    function automatic logic is_left_just(input logic [1:0] code);
        return (fmt_e'(code) == FMT_LEFT);
    endfunction

    // Word length on the bus for a size code; only 16 bits is implemented.
    function automatic int unsigned size_word_bits(input logic [1:0] code);
        int unsigned bits;
        case (code)
            2'd0:    bits = 16;
            default: bits = 16;
        endcase
        return bits;
    endfunction

endpackage

// File: rtl/i2stx_clk_div.sv
// Module: bit-clock generator for master mode.
// Divides the system clock so the bit clock toggles every DIV_HALF cycles and
// flags the cycle that ends with a falling bit-clock edge.
// Assumes: DIV_HALF >= 2; held in its reset state while run is low.
module i2stx_clk_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic fall_evt
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          sck_q;
    logic          term;

    // Terminal count of the half-period counter.
    assign term     = (cnt_q == TERM);
    assign fall_evt = run && term && sck_q;
    assign sck      = sck_q;

    // Half-period counter and bit-clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the bit clock only moves after a full half period has been counted.
    a_r5_sck_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck_q) |-> ($past(cnt_q) == TERM));

endmodule

// File: rtl/i2stx_edge_sync.sv
// Module: slave-mode input stage.
// Brings the external bit clock and word select through two-flop synchronizers
// and flags the system cycle in which a falling bit-clock edge is seen.
// Assumes: each external bit-clock half period lasts at least 4 system cycles.
module i2stx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_ext,
    input  logic ws_ext,
    output logic ws_sync,
    output logic fall_evt
);
    logic [1:0] sck_pipe;
    logic [1:0] ws_pipe;
    logic       sck_prev;

    // Two-flop synchronizers plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            ws_pipe  <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[0], sck_ext};
            ws_pipe  <= {ws_pipe[0], ws_ext};
            sck_prev <= sck_pipe[1];
        end
    end

    // Falling edge: previous synchronized level high, current one low.
    assign fall_evt = sck_prev && !sck_pipe[1];
    assign ws_sync  = ws_pipe[1];

    // R9: a detected fall lasts one system cycle.
    a_r9_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt);

endmodule

// File: rtl/i2stx_shifter.sv
// Module: frame sequencer and data shifter.
// Tracks the slot within a 2*SAMPLE_W frame, loads a sample pair (or silence)
// at slot 0, and updates serial data and word select on each falling bit-clock
// event, with or without a one-bit delay.
// Assumes: master and left_just are static between resets.
module i2stx_shifter #(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fall_evt,
    input  logic                  master,
    input  logic                  left_just,
    input  logic                  ws_ext,
    input  logic                  s_valid,
    input  logic [2*SAMPLE_W-1:0] s_pair,
    output logic                  s_ready,
    output logic                  sd,
    output logic                  ws,
    output logic                  underflow
);
    localparam int SLOTS = 2 * SAMPLE_W;
    localparam int SW    = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
    localparam logic [SW-1:0] HALF = SW'(SAMPLE_W);

    logic [SW-1:0]    slot_q, nslot, slot_inc;
    logic [SLOTS-1:0] shreg_q, cur;
    logic             ws_q, sd_q, last_q, uf_q;
    logic             frame_start, bit_now;

    // Slot that the coming falling edge opens; slave mode realigns on word select.
    always_comb begin
        slot_inc = (slot_q == LAST) ? '0 : slot_q + 1'b1;
        if (master)
            nslot = slot_inc;
        else if (ws_ext != ws_q)
            nslot = ws_ext ? HALF : '0;
        else
            nslot = slot_inc;
    end

    // Frame boundary, handshake and the bit belonging to the new slot.
    always_comb begin
        frame_start = fall_evt && (nslot == '0);
        cur         = frame_start ? (s_valid ? s_pair : '0) : shreg_q;
        bit_now     = cur[SLOTS-1];
    end

    assign s_ready   = frame_start;
    assign sd        = sd_q;
    assign ws        = ws_q;
    assign underflow = uf_q;

    // State advance on each falling bit-clock event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= LAST;
            shreg_q <= '0;
            ws_q    <= 1'b1;
            sd_q    <= 1'b0;
            last_q  <= 1'b0;
            uf_q    <= 1'b0;
        end else if (fall_evt) begin
            slot_q  <= nslot;
            shreg_q <= cur << 1;
            sd_q    <= left_just ? bit_now : last_q;
            last_q  <= bit_now;
            ws_q    <= master ? (nslot >= HALF) : ws_ext;
            if (frame_start && !s_valid)
                uf_q <= 1'b1;
        end
    end

    // R8: the underflow flag never clears outside reset.
    a_r8_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |=> uf_q);

    // R7: an accepted pair always opens slot 0.
    a_r7_ready_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> (slot_q == '0));

    // R4: in master mode word select moves only at the channel boundaries.
    a_r4_ws_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !$stable(ws_q)) |-> (slot_q == '0 || slot_q == HALF));

    // R5: serial data holds between falling bit-clock events.
    a_r5_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(sd_q));

endmodule

// File: rtl/i2s_tx_serializer.sv
// Module: top of the I2S transmit serializer.
// Picks the falling-edge source (internal divider or synchronized external
// clock), decodes the format code and drives the serial outputs.
// Assumes: cfg_* inputs change only while rst_n is low.
module i2s_tx_serializer #(
    parameter int SAMPLE_W = 16,
    parameter int DIV_HALF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_master,
    input  logic [1:0]          cfg_fmt,
    input  logic [1:0]          cfg_size,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    input  logic                sck_in,
    input  logic                ws_in,
    output logic                sck_out,
    output logic                ws_out,
    output logic                sd_out,
    output logic                underflow
);
    import i2stx_pkg::*;

    logic        m_sck, m_fall;
    logic        x_ws, x_fall;
    logic        fall_evt, left_just, ws_int;
    int unsigned word_bits;

    // Format and size decode.
    assign left_just = is_left_just(cfg_fmt);
    assign word_bits = size_word_bits(cfg_size);

    i2stx_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_master),
        .sck      (m_sck),
        .fall_evt (m_fall)
    );

    i2stx_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_ext  (sck_in),
        .ws_ext   (ws_in),
        .ws_sync  (x_ws),
        .fall_evt (x_fall)
    );

    // Falling-edge source follows the clock role.
    assign fall_evt = cfg_master ? m_fall : x_fall;

    i2stx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_evt  (fall_evt),
        .master    (cfg_master),
        .left_just (left_just),
        .ws_ext    (x_ws),
        .s_valid   (s_valid),
        .s_pair    ({s_left, s_right}),
        .s_ready   (s_ready),
        .sd        (sd_out),
        .ws        (ws_int),
        .underflow (underflow)
    );

    // Clock outputs are driven only in master mode.
    assign sck_out = cfg_master && m_sck;
    assign ws_out  = cfg_master && ws_int;

    // R6: every size code decodes to the implemented word length.
    always_comb begin
        if (rst_n) begin
            a_r6_size_word: assert (word_bits == SAMPLE_W);
        end
    end

    // R9: in slave mode the clock outputs stay low.
    a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!sck_out && !ws_out));

endmodule

// File: tb/tb_i2s_tx_serializer.sv
// Bench: a behavioural cycle model (frame captured whole, bits indexed by slot)
// compared against the DUT on every system clock, away from the active edge.
module tb_i2s_tx_serializer;
    localparam int W        = 16;
    localparam int DIV      = 4;
    localparam int EXT_HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  cfg_size = 2'd0;
    logic        s_valid = 1'b1;
    logic        s_ready;
    logic [W-1:0] s_left = 16'hA5C3;
    logic [W-1:0] s_right = 16'h3C5A;
    logic        sck_in = 1'b0;
    logic        ws_in = 1'b1;
    logic        sck_out, ws_out, sd_out, underflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    string sd_tag = "R1";
    string ws_tag = "R4";
    string ck_tag = "R5";

    i2s_tx_serializer #(.SAMPLE_W(W), .DIV_HALF(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
        .cfg_size(cfg_size), .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right), .sck_in(sck_in), .ws_in(ws_in),
        .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out), .underflow(underflow)
    );

    always #5 clk = ~clk;

    // Reference model state.
    int          m_cnt, m_slot, hs_count;
    bit          m_sck, m_ws, m_sd, m_last, m_uf;
    bit          p1, p2, p3, q1, q2;
    logic [31:0] m_frame;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    // Whether the current cycle ends in a falling bit-clock event, and the slot it opens.
    task automatic next_event(output bit fall, output int nslot);
        if (cfg_master) begin
            fall  = (m_cnt == DIV - 1) && m_sck;
            nslot = (m_slot + 1) % 32;
        end else begin
            fall = p3 && !p2;
            if (q2 != m_ws) nslot = q2 ? 16 : 0;
            else            nslot = (m_slot + 1) % 32;
        end
    endtask

    // Model update at the active edge.
    always @(posedge clk) begin : model
        bit f;
        int ns;
        bit b;
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_sck = 0; m_slot = 31; m_ws = 1; m_sd = 0; m_last = 0;
            m_uf = 0; m_frame = '0; p1 = 0; p2 = 0; p3 = 0; q1 = 0; q2 = 0;
        end else begin
            next_event(f, ns);
            if (f) begin
                if (ns == 0) begin
                    if (s_valid) begin
                        m_frame = {s_left, s_right};
                        hs_count++;
                    end else begin
                        m_frame = '0;
                        m_uf = 1;
                    end
                end
                b = m_frame[31-ns];
                m_sd = (cfg_fmt == 2'd2) ? b : m_last;
                m_last = b;
                m_ws = cfg_master ? (ns >= 16) : q2;
                m_slot = ns;
            end
            if (cfg_master) begin
                if (m_cnt == DIV - 1) begin m_cnt = 0; m_sck = !m_sck; end
                else m_cnt++;
            end
            p3 = p2; p2 = p1; p1 = sck_in;
            q2 = q1; q1 = ws_in;
        end
    end

    // Compare, refill samples and run the external clock, all on the inactive edge.
    always @(negedge clk) begin : compare
        bit f;
        int ns;
        int seen;
        int ext_cnt;
        int ext_slot;
        if (cmp_en) begin
            next_event(f, ns);
            chk(sck_out, cfg_master ? m_sck : 1'b0, ck_tag, "sck_out");
            chk(ws_out, cfg_master ? m_ws : 1'b0, ws_tag, "ws_out");
            chk(sd_out, m_sd, sd_tag, "sd_out");
            chk(s_ready, f && (ns == 0), "R7", "s_ready");
            chk(underflow, m_uf, "R8", "underflow");
        end
        if (seen != hs_count) begin
            seen = hs_count;
            s_left  = W'($urandom);
            s_right = W'($urandom);
        end
        if (!rst_n) begin
            ext_cnt = 0; ext_slot = 31; sck_in = 0; ws_in = 1;
        end else if (!cfg_master) begin
            ext_cnt++;
            if (ext_cnt == EXT_HALF) begin
                ext_cnt = 0;
                if (sck_in) begin
                    sck_in = 0;
                    ext_slot = (ext_slot + 1) % 32;
                    ws_in = (ext_slot >= 16);
                end else begin
                    sck_in = 1;
                end
            end
        end
    end

    // Apply a configuration under reset and check the reset state (R10).
    task automatic start_phase(input bit master, input logic [1:0] fmt,
                               input logic [1:0] size, input string sdt,
                               input string wst);
        @(negedge clk);
        cmp_en = 0;
        rst_n = 0;
        cfg_master = master;
        cfg_fmt = fmt;
        cfg_size = size;
        s_valid = 1;
        sd_tag = sdt;
        ws_tag = wst;
        ck_tag = master ? "R5" : "R9";
        repeat (3) @(negedge clk);
        chk(sd_out, 0, "R10", "reset sd_out");
        chk(sck_out, 0, "R10", "reset sck_out");
        chk(s_ready, 0, "R10", "reset s_ready");
        chk(underflow, 0, "R10", "reset underflow");
        chk(ws_out, master ? 1 : 0, "R10", "reset ws_out");
        cmp_en = 1;
        rst_n = 1;
    endtask

    initial begin
        // R1: left-justified master stream.
        start_phase(1, 2'd2, 2'd0, "R1", "R4");
        repeat (1100) @(negedge clk);
        // R2: standard framing with one-bit delay.
        start_phase(1, 2'd0, 2'd0, "R2", "R4");
        repeat (1100) @(negedge clk);
        // R3: reserved code 1 behaves as standard.
        start_phase(1, 2'd1, 2'd0, "R3", "R4");
        repeat (1100) @(negedge clk);
        // R6 (and R3): reserved code 3 with size code 3 still 16-bit standard.
        start_phase(1, 2'd3, 2'd3, "R6", "R4");
        repeat (1100) @(negedge clk);
        // R8: producer stalls longer than a frame, then resumes.
        start_phase(1, 2'd0, 2'd0, "R8", "R4");
        repeat (300) @(negedge clk);
        s_valid = 0;
        repeat (400) @(negedge clk);
        s_valid = 1;
        repeat (600) @(negedge clk);
        chk(underflow, 1, "R8", "sticky after recovery");
        // R9: slave mode, standard then left-justified framing.
        start_phase(0, 2'd0, 2'd0, "R9", "R9");
        repeat (1500) @(negedge clk);
        start_phase(0, 2'd2, 2'd0, "R9", "R9");
        repeat (1500) @(negedge clk);
        cmp_en = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule